// File: doc/BRIEF.md
# Transmit Phase-Align FIFO with Error Fill

This block sits at the transmit end of a serial link. It moves 10-bit characters from the clock that writes them into the internal character-rate clock that feeds the serializer. The write clock is either a host-supplied clock or the reference clock, chosen by a select input. Characters are written into a small dual-clock ring buffer on every write-clock edge. They are read out one per character clock. Because of this, the host clock can wander in phase against the character clock without any data being lost.

A configuration input, active low, re-centres the buffer. The read position is placed a fixed distance behind the synchronised write position, and any pending error is cleared. If the read side ever finds the buffer empty (underflow), or finds that unread entries have been overwritten (overflow), it raises a sticky error. The error stays up until the next re-centring. While the error is up, the output carries a constant fill character in place of data, so the far end can see the fault.

When the reference clock is selected and it runs at the full character rate, the buffer is bypassed. The input is then registered directly on the character clock.

Top module: `txpa_fifo`

## Requirements
- R1: While reset is asserted, and after reset until the first re-centring, `pa_err` is 1 and `tx_char` equals the fill character.
- R2: The buffer is written on `host_clk` when `clk_sel` is 0 and on `ref_clk` when `clk_sel` is 1. A stopped selected clock leads to underflow even when the other clock runs.
- R3: When `clk_sel` and `full_rate` are both 1 (bypass), `tx_char` equals the `in_data` value sampled at the previous `chr_clk` edge, and `pa_err` is 0.
- R4: A `chr_clk` edge with `centre_n` low (outside bypass) clears `pa_err`, outputs the fill character, and sets the read position CENTRE (default 4) entries behind the synchronised write position. The next CENTRE reads then deliver the last CENTRE characters written, in order.
- R5: With the write clock at the same frequency as `chr_clk`, at any fixed phase and across a single half-period phase jump, the output after a re-centring is the written sequence with no gap and with `pa_err` at 0.
- R6: A read attempted while the buffer holds no unread character sets `pa_err` at that edge.
- R7: A read attempted after more than DEPTH (default 16) characters are pending sets `pa_err` at that edge.
- R8: Once set, `pa_err` stays at 1 until a re-centring edge (or bypass), whatever the clocks do in between.
- R9: While `pa_err` is 1, `tx_char` is 10'b1001111000 (hex 278). Bit 9 is the leftmost digit, and bit 0 is the first bit the serializer sends.
- R10: When a re-centring edge coincides with an underflow or overflow, the re-centring wins and `pa_err` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| host_clk | input | 1 | Host-supplied write clock |
| ref_clk | input | 1 | Reference clock, alternative write clock |
| chr_clk | input | 1 | Internal character-rate read clock |
| clk_sel | input | 1 | 0 selects host_clk as write clock, 1 selects ref_clk |
| full_rate | input | 1 | 1 marks the reference clock as full character rate |
| centre_n | input | 1 | Active-low re-centring command, sampled on chr_clk |
| in_data | input | 10 | Character to transmit |
| tx_char | output | 10 | Character delivered to the serializer |
| pa_err | output | 1 | Sticky capacity-exceeded error |

## Verification
Re-centring and capacity-exceeded detection can fall on the same character-clock edge, and the bench forces this on purpose. It stops the write clock so the buffer drains and the error latches. It then applies a one-cycle re-centring pulse while the read side still sees an empty buffer, so the underflow condition is true on the very edge that re-centres. The bench expects `pa_err` to be low right after that edge. It then expects exactly four data reads, the last one equal to the final character written, and the error to return on the fifth edge, when the buffer is empty again.

// File: rtl/txpa_fifo.sv
module txpa_fifo #(
  parameter int W = 10,
  parameter int DEPTH = 16,
  parameter int CENTRE = 4,
  parameter logic [W-1:0] FILL = 10'b1001111000
) (
  input  logic         rst_n,
  input  logic         host_clk,
  input  logic         ref_clk,
  input  logic         chr_clk,
  input  logic         clk_sel,
  input  logic         full_rate,
  input  logic         centre_n,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] tx_char,
  output logic         pa_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 2;
  localparam logic [PW-1:0] DLIM = PW'(DEPTH);
  localparam logic [PW-1:0] CENT = PW'(CENTRE);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return (b >> 1) ^ b;
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic wclk, bypass;
  assign wclk   = clk_sel ? ref_clk : host_clk;
  assign bypass = clk_sel & full_rate;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, wnext;
  assign wnext = wbin + 1'b1;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wnext;
      wgray <= to_gray(wnext);
    end

  always_ff @(posedge wclk) mem[wbin[AW-1:0]] <= in_data;

  logic [PW-1:0] ws1, ws2, wsb, rbin, occ;
  logic under, over;

  always_ff @(posedge chr_clk or negedge rst_n)
    if (!rst_n) begin
      ws1 <= '0;
      ws2 <= '0;
    end else begin
      ws1 <= wgray;
      ws2 <= ws1;
    end

  assign wsb   = from_gray(ws2);
  assign occ   = wsb - rbin;
  assign under = (occ == '0) | occ[PW-1];
  assign over  = ~occ[PW-1] & (occ > DLIM);

  always_ff @(posedge chr_clk or negedge rst_n)
    if (!rst_n) begin
      rbin    <= '0;
      pa_err  <= 1'b1;
      tx_char <= FILL;
    end else if (bypass) begin
      pa_err  <= 1'b0;
      tx_char <= in_data;
    end else if (!centre_n) begin
      rbin    <= wsb - CENT;
      pa_err  <= 1'b0;
      tx_char <= FILL;
    end else if (pa_err || under || over) begin
      pa_err  <= 1'b1;
      tx_char <= FILL;
    end else begin
      tx_char <= mem[rbin[AW-1:0]];
      rbin    <= rbin + 1'b1;
    end
endmodule

// File: rtl/txpa_fifo_chk.sv
module txpa_fifo_chk #(
  parameter int W = 10,
  parameter logic [W-1:0] FILL = 10'b1001111000
) (
  input logic         chr_clk,
  input logic         rst_n,
  input logic         clk_sel,
  input logic         full_rate,
  input logic         centre_n,
  input logic [W-1:0] in_data,
  input logic [W-1:0] tx_char,
  input logic         pa_err,
  input logic         under,
  input logic         over
);
  logic byp;
  assign byp = clk_sel & full_rate;

  always @(posedge chr_clk)
    if (!rst_n) a_r1_reset_fill: assert (pa_err && tx_char == FILL);

  a_r3_bypass_pass: assert property (@(posedge chr_clk) disable iff (!rst_n)
    byp |=> (tx_char == $past(in_data) && !pa_err));

  a_r4_centre_clears: assert property (@(posedge chr_clk) disable iff (!rst_n)
    (!byp && !centre_n) |=> !pa_err);

  a_r6_underflow: assert property (@(posedge chr_clk) disable iff (!rst_n)
    (!byp && centre_n && under) |=> pa_err);

  a_r7_overflow: assert property (@(posedge chr_clk) disable iff (!rst_n)
    (!byp && centre_n && over) |=> pa_err);

  a_r8_sticky: assert property (@(posedge chr_clk) disable iff (!rst_n)
    (pa_err && centre_n && !byp) |=> pa_err);

  a_r9_fill: assert property (@(posedge chr_clk) disable iff (!rst_n)
    pa_err |-> tx_char == FILL);
endmodule

bind txpa_fifo txpa_fifo_chk #(.W(W), .FILL(FILL)) u_chk (
  .chr_clk(chr_clk), .rst_n(rst_n), .clk_sel(clk_sel), .full_rate(full_rate),
  .centre_n(centre_n), .in_data(in_data), .tx_char(tx_char), .pa_err(pa_err),
  .under(under), .over(over)
);

// File: tb/txpa_fifo_bench.sv
`timescale 1ns/1ps
module txpa_fifo_bench;
  localparam logic [9:0] FILL = 10'h278;
  localparam int CENTRE = 4;

  logic rst_n = 1'b1;
  logic host_clk = 1'b0, ref_clk = 1'b0, chr_clk = 1'b0;
  logic clk_sel = 1'b0, full_rate = 1'b0, centre_n = 1'b1;
  logic [9:0] in_data = '0;
  logic [9:0] tx_char;
  logic pa_err;
  logic host_run = 1'b0, ref_run = 1'b0, auto_inc = 1'b1;
  real host_half = 2.5;
  int checks = 0, errors = 0;

  txpa_fifo u_txpa_fifo (
    .rst_n(rst_n), .host_clk(host_clk), .ref_clk(ref_clk), .chr_clk(chr_clk),
    .clk_sel(clk_sel), .full_rate(full_rate), .centre_n(centre_n),
    .in_data(in_data), .tx_char(tx_char), .pa_err(pa_err)
  );

  always #2.5 chr_clk = ~chr_clk;
  initial forever begin #(host_half); if (host_run) host_clk = ~host_clk; end
  initial forever begin #2.5; if (ref_run) ref_clk = ~ref_clk; end

  wire bclk = clk_sel ? ref_clk : host_clk;
  always @(negedge bclk) if (auto_inc) in_data <= in_data + 10'd1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic centre();
    @(negedge chr_clk); centre_n = 1'b0;
    @(negedge chr_clk); centre_n = 1'b1;
  endtask

  task automatic stream(input int n, input string tag);
    logic [9:0] prev;
    int bad = 0;
    @(negedge chr_clk); prev = tx_char; if (pa_err) bad++;
    for (int k = 1; k < n; k++) begin
      @(negedge chr_clk);
      if (pa_err || tx_char !== prev + 10'd1) bad++;
      prev = tx_char;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic wait_err(input int n);
    repeat (n) begin @(negedge chr_clk); if (pa_err) break; end
  endtask

  task automatic stop_host();
    @(negedge host_clk); host_run = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge chr_clk);
    chk(pa_err && tx_char == FILL, "R1 during reset", {pa_err, tx_char}, {1'b1, FILL});
    rst_n = 1'b1;
    #0.7 host_run = 1'b1;
    repeat (40) @(negedge chr_clk);
    chk(pa_err == 1'b1, "R1/R8 err before centring", pa_err, 1);
    chk(tx_char == FILL, "R1/R9 fill before centring", tx_char, FILL);
  endtask

  task automatic t_steady();
    centre();
    chk(pa_err == 1'b0, "R4 centring clears err", pa_err, 0);
    repeat (8) @(negedge chr_clk);
    stream(200, "R5 same-rate stream");
    stop_host();
    #2.5 host_run = 1'b1;
    repeat (4) @(negedge chr_clk);
    stream(200, "R5 after half-period jump");
  endtask

  task automatic t_under();
    host_half = 2.6;
    wait_err(600);
    chk(pa_err == 1'b1, "R6 slow writer underflows", pa_err, 1);
    chk(tx_char == FILL, "R9 fill on underflow", tx_char, FILL);
    host_half = 2.5;
    repeat (60) @(negedge chr_clk);
    chk(pa_err == 1'b1, "R8 err sticky", pa_err, 1);
    centre();
    repeat (8) @(negedge chr_clk);
    stream(100, "R4 recovery after underflow");
  endtask

  task automatic t_over();
    host_half = 2.4;
    wait_err(1500);
    chk(pa_err == 1'b1, "R7 fast writer overflows", pa_err, 1);
    chk(tx_char == FILL, "R9 fill on overflow", tx_char, FILL);
    host_half = 2.5;
    repeat (30) @(negedge chr_clk);
    chk(pa_err == 1'b1, "R8 err sticky after overflow", pa_err, 1);
    centre();
    repeat (8) @(negedge chr_clk);
    stream(100, "R4 recovery after overflow");
  endtask

  task automatic t_prio();
    logic [9:0] last;
    int bad = 0;
    stop_host();
    repeat (30) @(negedge chr_clk);
    chk(pa_err == 1'b1, "R6 stopped writer drains", pa_err, 1);
    last = in_data - 10'd1;
    centre();
    chk(pa_err == 1'b0 && tx_char == FILL, "R10 centre wins over underflow",
        {pa_err, tx_char}, {1'b0, FILL});
    for (int k = 1; k <= CENTRE; k++) begin
      @(negedge chr_clk);
      if (pa_err || tx_char !== last - 10'(CENTRE - k)) bad++;
    end
    chk(bad == 0, "R4 last CENTRE characters replayed", bad, 0);
    chk(tx_char == last, "R4 final replayed character", tx_char, last);
    @(negedge chr_clk);
    chk(pa_err == 1'b1, "R6 underflow after replay", pa_err, 1);
  endtask

  task automatic t_refsel();
    clk_sel = 1'b1;
    ref_run = 1'b1;
    repeat (10) @(negedge chr_clk);
    centre();
    repeat (8) @(negedge chr_clk);
    stream(100, "R2 ref clock writes buffer");
    @(negedge ref_clk); ref_run = 1'b0;
    clk_sel = 1'b0;
    ref_run = 1'b1;
    centre();
    wait_err(40);
    chk(pa_err == 1'b1, "R2 host selected and stopped", pa_err, 1);
    @(negedge ref_clk); ref_run = 1'b0;
  endtask

  task automatic t_bypass();
    logic [9:0] pat [4] = '{10'h155, 10'h2AA, 10'h3FF, 10'h000};
    int bad = 0;
    auto_inc = 1'b0;
    clk_sel = 1'b1;
    full_rate = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge chr_clk); in_data = pat[k];
      @(negedge chr_clk);
      if (tx_char !== pat[k] || pa_err) bad++;
    end
    chk(bad == 0, "R3 bypass passes input", bad, 0);
    chk(pa_err == 1'b0, "R3 bypass clears err", pa_err, 0);
  endtask

  initial begin
    #900000;
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_steady();
    t_under();
    t_over();
    t_prio();
    t_refsel();
    t_bypass();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule